// File: doc/BRIEF.md
# Triplicated Link Codec with Parity-Guided Copy Selection

This block guards a message word that crosses a long wire bundle between two routers. On the sending side each message bit is driven onto three neighbouring wires and one extra wire carries the parity of those copy wires. Because every wire shares a neighbour carrying the same value, no wire ever sees both of its neighbours switch against it, so the worst crosstalk pattern on the bundle cannot occur.

On the receiving side the bundle is split back into three copies of the message. The decoder takes the parity of each copy and compares it with the transmitted parity bit. When the copy parities disagree, the first copy whose parity matches the transmitted bit is forwarded. When they all agree, the decoder falls back to comparing whole copies. A flag marks a word whose copy parities all agree but contradict the transmitted bit. This is the signature of a three-wire burst that hits each copy once.

Both directions are valid/ready streams. A word moves when valid and ready are both high at a rising clock edge. A sender must hold valid and payload steady until the word is taken. With the output register enabled, a stage accepts a new word in the same cycle its held word leaves, so a stalled consumer stalls the producer without losing a word.

Top module: `tap_link_codec`

## Requirements
- R1: The encoded word places message bit i on wires 3i, 3i+1 and 3i+2. Wire 96 carries the XOR of wires 0..95, which equals the parity of the message.
- R2: Between two successively transferred encoded words, no copy wire j (1..95) switches while both wire j-1 and wire j+1 switch in the direction opposite to it.
- R3: An error-free encoded word decodes to its message with the burst flag low.
- R4: A word with any single wire inverted decodes to the original message. The burst flag is low unless the inverted wire is the parity wire 96, in which case it is high.
- R5: A word with any two distinct copy wires (0..95) inverted decodes to the original message with the burst flag low.
- R6: Copy A is wires 3i, copy B is wires 3i+1 and copy C is wires 3i+2. When the three copy parities are not all equal, the output is the first of A, B, C whose parity equals wire 96. When they are all equal, the output is A if A equals B, otherwise B if B equals C, otherwise C.
- R7: The burst flag is high exactly when the three copy parities are equal and differ from wire 96. Three adjacent copy wires inverted always raise it.
- R8: With the output register enabled, a word accepted at an edge appears at the output after that edge. Words leave in order, none is lost and none is duplicated.
- R9: While an output is valid and not ready, it keeps valid high and its payload unchanged. An input is ready exactly when its output is empty or being taken in that cycle.
- R10: While reset is asserted, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Message word offered to the encoder |
| enc_in_ready | output | 1 | Encoder stage can take a word |
| enc_in_msg | input | MSG_W | Message to encode |
| enc_out_valid | output | 1 | Encoded word available |
| enc_out_ready | input | 1 | Link side takes the encoded word |
| enc_out_code | output | 3*MSG_W+1 | Encoded link word |
| dec_in_valid | input | 1 | Received link word offered |
| dec_in_ready | output | 1 | Decoder stage can take a word |
| dec_in_code | input | 3*MSG_W+1 | Received link word |
| dec_out_valid | output | 1 | Corrected message available |
| dec_out_ready | input | 1 | Consumer takes the corrected message |
| dec_out_msg | output | MSG_W | Corrected message |
| dec_out_burst | output | 1 | Three-wire burst signature seen |

## Verification
The bench targets words whose errors fall in two different copies at the same bit index. A decoder that trusted parity order blindly would forward a damaged copy there. It also injects three-wire bursts at every phase relative to the copy grouping, where a wrong comparison chain forwards the wrong copy or leaves the flag low. A lone hit on the parity wire must leave the data intact while raising the flag, which catches a decoder that lets the parity wire steer the copy choice. Random back-pressure on both outputs exposes a stage that drops, repeats or changes a stalled word.

// File: rtl/tap_codec_pkg.sv
`timescale 1ns/1ps
package tap_codec_pkg;
  // number of wire copies carried per message bit
  localparam int unsigned COPIES = 3;

  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2
  } copy_sel_e;
endpackage

// File: rtl/tap_encoder.sv
`timescale 1ns/1ps
module tap_encoder import tap_codec_pkg::*; #(
  parameter int unsigned MSG_W = 32,
  localparam int unsigned TRIP_W = COPIES * MSG_W,
  localparam int unsigned LINK_W = TRIP_W + 1
) (
  input  logic [MSG_W-1:0]  msg_i,
  output logic [LINK_W-1:0] code_o
);
  logic [TRIP_W-1:0] trip;

  for (genvar i = 0; i < MSG_W; i++) begin : g_bit
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
      assign trip[COPIES*i + c] = msg_i[i];
    end
  end

  assign code_o = {^trip, trip};
endmodule

// File: rtl/tap_group_split.sv
`timescale 1ns/1ps
module tap_group_split import tap_codec_pkg::*; #(
  parameter int unsigned MSG_W = 32,
  localparam int unsigned LINK_W = COPIES * MSG_W + 1
) (
  input  logic [LINK_W-1:0] code_i,
  output logic [MSG_W-1:0]  grp_a_o,
  output logic [MSG_W-1:0]  grp_b_o,
  output logic [MSG_W-1:0]  grp_c_o,
  output logic              sent_par_o
);
  for (genvar i = 0; i < MSG_W; i++) begin : g_take
    assign grp_a_o[i] = code_i[COPIES*i];
    assign grp_b_o[i] = code_i[COPIES*i + 1];
    assign grp_c_o[i] = code_i[COPIES*i + 2];
  end

  assign sent_par_o = code_i[LINK_W-1];
endmodule

// File: rtl/tap_decoder.sv
`timescale 1ns/1ps
module tap_decoder import tap_codec_pkg::*; #(
  parameter int unsigned MSG_W = 32,
  localparam int unsigned LINK_W = COPIES * MSG_W + 1
) (
  input  logic [LINK_W-1:0] code_i,
  output logic [MSG_W-1:0]  msg_o,
  output logic              burst_o
);
  logic [MSG_W-1:0] grp_a, grp_b, grp_c;
  logic             sent_par;
  logic             par_a, par_b, par_c;
  logic             par_agree;
  copy_sel_e        pick;

  tap_group_split #(.MSG_W(MSG_W)) u_split (
    .code_i    (code_i),
    .grp_a_o   (grp_a),
    .grp_b_o   (grp_b),
    .grp_c_o   (grp_c),
    .sent_par_o(sent_par)
  );

  assign par_a     = ^grp_a;
  assign par_b     = ^grp_b;
  assign par_c     = ^grp_c;
  assign par_agree = (par_a == par_b) && (par_b == par_c);

  // parity-led choice, whole-copy comparison when parities give no hint
  always_comb begin
    if (par_agree) begin
      if (grp_a == grp_b)      pick = SEL_A;
      else if (grp_b == grp_c) pick = SEL_B;
      else                     pick = SEL_C;
    end else begin
      if (par_a == sent_par)      pick = SEL_A;
      else if (par_b == sent_par) pick = SEL_B;
      else                        pick = SEL_C;
    end
  end

  always_comb begin
    unique case (pick)
      SEL_A:   msg_o = grp_a;
      SEL_B:   msg_o = grp_b;
      default: msg_o = grp_c;
    endcase
  end

  assign burst_o = par_agree && (par_a != sent_par);
endmodule

// File: rtl/tap_pipe_stage.sv
`timescale 1ns/1ps
module tap_pipe_stage #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REG) begin : g_reg
    logic         held_v;
    logic [W-1:0] held_d;

    assign in_ready  = !held_v || out_ready;
    assign out_valid = held_v;
    assign out_data  = held_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held_v <= 1'b0;
      else if (in_ready) held_v <= in_valid;
    end

    always_ff @(posedge clk) begin
      if (in_ready && in_valid) held_d <= in_data;
    end
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/tap_link_codec.sv
`timescale 1ns/1ps
module tap_link_codec import tap_codec_pkg::*; #(
  parameter int unsigned MSG_W   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_in_valid,
  output logic               enc_in_ready,
  input  logic [MSG_W-1:0]   enc_in_msg,
  output logic               enc_out_valid,
  input  logic               enc_out_ready,
  output logic [3*MSG_W:0]   enc_out_code,
  input  logic               dec_in_valid,
  output logic               dec_in_ready,
  input  logic [3*MSG_W:0]   dec_in_code,
  output logic               dec_out_valid,
  input  logic               dec_out_ready,
  output logic [MSG_W-1:0]   dec_out_msg,
  output logic               dec_out_burst
);
  localparam int unsigned LINK_W = COPIES * MSG_W + 1;

  logic [LINK_W-1:0] enc_code;
  logic [MSG_W-1:0]  dec_msg;
  logic              dec_burst;

  tap_encoder #(.MSG_W(MSG_W)) u_enc (
    .msg_i (enc_in_msg),
    .code_o(enc_code)
  );

  tap_pipe_stage #(.W(LINK_W), .REG(REG_OUT)) u_enc_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (enc_in_valid),
    .in_ready (enc_in_ready),
    .in_data  (enc_code),
    .out_valid(enc_out_valid),
    .out_ready(enc_out_ready),
    .out_data (enc_out_code)
  );

  tap_decoder #(.MSG_W(MSG_W)) u_dec (
    .code_i (dec_in_code),
    .msg_o  (dec_msg),
    .burst_o(dec_burst)
  );

  tap_pipe_stage #(.W(MSG_W+1), .REG(REG_OUT)) u_dec_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (dec_in_valid),
    .in_ready (dec_in_ready),
    .in_data  ({dec_burst, dec_msg}),
    .out_valid(dec_out_valid),
    .out_ready(dec_out_ready),
    .out_data ({dec_out_burst, dec_out_msg})
  );
endmodule

// File: rtl/tap_link_codec_chk.sv
`timescale 1ns/1ps
module tap_link_codec_chk #(
  parameter int unsigned MSG_W   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_in_valid,
  input logic             enc_in_ready,
  input logic [MSG_W-1:0] enc_in_msg,
  input logic             enc_out_valid,
  input logic             enc_out_ready,
  input logic [3*MSG_W:0] enc_out_code,
  input logic             dec_in_valid,
  input logic             dec_in_ready,
  input logic [3*MSG_W:0] dec_in_code,
  input logic             dec_out_valid,
  input logic             dec_out_ready,
  input logic [MSG_W-1:0] dec_out_msg,
  input logic             dec_out_burst
);
  localparam int unsigned TRIP_W = 3 * MSG_W;

  logic             layout_ok;
  logic             in_clean;
  logic [MSG_W-1:0] in_copy_a;
  logic [TRIP_W:0]  last_code;
  logic             have_last;
  logic             opposite_hit;
  logic             enc_fire;

  assign enc_fire = enc_out_valid && enc_out_ready;

  always_comb begin
    layout_ok = (enc_out_code[TRIP_W] == ^enc_out_code[TRIP_W-1:0]);
    in_clean  = (dec_in_code[TRIP_W] == ^dec_in_code[TRIP_W-1:0]);
    for (int i = 0; i < MSG_W; i++) begin
      in_copy_a[i] = dec_in_code[3*i];
      if (enc_out_code[3*i] != enc_out_code[3*i+1] ||
          enc_out_code[3*i] != enc_out_code[3*i+2]) layout_ok = 1'b0;
      if (dec_in_code[3*i] != dec_in_code[3*i+1] ||
          dec_in_code[3*i] != dec_in_code[3*i+2]) in_clean = 1'b0;
    end
  end

  always_comb begin
    opposite_hit = 1'b0;
    for (int j = 1; j < TRIP_W; j++) begin
      if (enc_out_code[j]   != last_code[j]   &&
          enc_out_code[j-1] != last_code[j-1] &&
          enc_out_code[j+1] != last_code[j+1] &&
          enc_out_code[j-1] != enc_out_code[j] &&
          enc_out_code[j+1] != enc_out_code[j]) opposite_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_code <= '0;
    end else if (enc_fire) begin
      have_last <= 1'b1;
      last_code <= enc_out_code;
    end
  end

  // R1
  enc_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> layout_ok);

  // R2
  no_opposite_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_fire && have_last) |-> !opposite_hit);

  if (REG_OUT) begin : g_reg_props
    // R9
    enc_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_out_valid && !enc_out_ready) |=> (enc_out_valid && $stable(enc_out_code)));

    // R9
    dec_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_out_valid && !dec_out_ready) |=>
        (dec_out_valid && $stable(dec_out_msg) && $stable(dec_out_burst)));

    // R3
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_in_valid && dec_in_ready && in_clean) |=>
        (dec_out_valid && dec_out_msg == $past(in_copy_a) && !dec_out_burst));

    // R8
    enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_in_valid && enc_in_ready) |=> enc_out_valid);
  end

  logic unused_ok;
  assign unused_ok = ^enc_in_msg;
endmodule

bind tap_link_codec tap_link_codec_chk #(.MSG_W(MSG_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_tap_link_codec.sv
`timescale 1ns/1ps
module tb_tap_link_codec;
  localparam int MW = 32;
  localparam int LW = 3*MW + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enc_in_valid, enc_in_ready;
  logic [MW-1:0] enc_in_msg;
  logic          enc_out_valid, enc_out_ready;
  logic [LW-1:0] enc_out_code;
  logic          dec_in_valid, dec_in_ready;
  logic [LW-1:0] dec_in_code;
  logic          dec_out_valid, dec_out_ready;
  logic [MW-1:0] dec_out_msg;
  logic          dec_out_burst;

  always #10 clk = ~clk;  // 50 MHz

  tap_link_codec #(.MSG_W(MW), .REG_OUT(1'b1)) dut (.*);

  int n_checks = 0;
  int n_err    = 0;

  logic [LW-1:0] enc_q[$];
  logic [MW:0]   dec_q[$];
  string         dtag_q[$];
  string         btag_q[$];

  logic [LW-1:0] last_enc;
  bit            have_last = 0;
  bit            enc_stall = 0, dec_stall = 0;
  bit            enc_in_stall = 0, dec_in_stall = 0;
  logic [LW-1:0] enc_hold;
  logic [MW:0]   dec_hold;
  logic [MW:0]   pend_exp;
  string         pend_dtag, pend_btag;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] ref_encode(input logic [MW-1:0] m);
    logic [LW-1:0] w;
    logic p;
    p = 1'b0;
    for (int i = 0; i < MW; i++) begin
      for (int k = 0; k < 3; k++) begin
        w[3*i+k] = m[i];
        p = p ^ m[i];
      end
    end
    w[LW-1] = p;
    return w;
  endfunction

  // builds a received word with a chosen error pattern and its expected result
  task automatic gen_dec(output logic [LW-1:0] w, output logic [MW:0] exp,
                         output string dtag, output string btag);
    logic [MW-1:0] m;
    int mode, a, b, k, g1, g2;
    m = $urandom;
    w = ref_encode(m);
    mode = $urandom_range(4);
    case (mode)
      0: begin exp = {1'b0, m}; dtag = "R3"; btag = "R3"; end
      1: begin
        a = $urandom_range(LW-1);
        w[a] = ~w[a];
        exp = {(a == LW-1), m}; dtag = "R4"; btag = "R4";
      end
      2: begin
        a = $urandom_range(95);
        b = (a + 1 + $urandom_range(94)) % 96;
        w[a] = ~w[a]; w[b] = ~w[b];
        exp = {1'b0, m}; dtag = "R5"; btag = "R5";
      end
      3: begin
        g1 = $urandom_range(2);
        g2 = (g1 + 1 + $urandom_range(1)) % 3;
        a = 3*$urandom_range(MW-1) + g1;
        b = 3*$urandom_range(MW-1) + g2;
        w[a] = ~w[a]; w[b] = ~w[b];
        exp = {1'b0, m}; dtag = "R6"; btag = "R5";
      end
      default: begin
        k = $urandom_range(93);
        w[k] = ~w[k]; w[k+1] = ~w[k+1]; w[k+2] = ~w[k+2];
        exp = {1'b1, m ^ (MW'(1) << ((k+1)/3))}; dtag = "R6"; btag = "R7";
      end
    endcase
  endtask

  // sample just before the rising edge, then move to the next falling edge
  task automatic tick();
    logic [MW:0] e;
    bit bad;
    #5;
    check(enc_in_ready == (!enc_out_valid || enc_out_ready), "R9 enc_in_ready", enc_in_ready, !enc_out_valid || enc_out_ready);
    check(dec_in_ready == (!dec_out_valid || dec_out_ready), "R9 dec_in_ready", dec_in_ready, !dec_out_valid || dec_out_ready);
    if (enc_stall) begin
      check(enc_out_valid, "R9 enc hold valid", enc_out_valid, 1);
      check(enc_out_code == enc_hold, "R9 enc hold code", enc_out_code, enc_hold);
    end
    if (dec_stall) begin
      check(dec_out_valid, "R9 dec hold valid", dec_out_valid, 1);
      check({dec_out_burst, dec_out_msg} == dec_hold, "R9 dec hold data", {dec_out_burst, dec_out_msg}, dec_hold);
    end
    if (enc_out_valid && enc_out_ready) begin
      if (enc_q.size() == 0) check(0, "R8 enc extra word", enc_out_code, 0);
      else begin
        check(enc_out_code == enc_q[0], "R1 encode", enc_out_code, enc_q[0]);
        void'(enc_q.pop_front());
      end
      if (have_last) begin
        bad = 0;
        for (int j = 1; j < LW-1; j++)
          if (enc_out_code[j] != last_enc[j] && enc_out_code[j-1] != last_enc[j-1] &&
              enc_out_code[j+1] != last_enc[j+1] && enc_out_code[j-1] != enc_out_code[j] &&
              enc_out_code[j+1] != enc_out_code[j]) bad = 1;
        check(!bad, "R2 opposite switching", bad, 0);
      end
      last_enc = enc_out_code; have_last = 1;
    end
    if (dec_out_valid && dec_out_ready) begin
      if (dec_q.size() == 0) check(0, "R8 dec extra word", dec_out_msg, 0);
      else begin
        e = dec_q.pop_front();
        check(dec_out_msg == e[MW-1:0], dtag_q[0], dec_out_msg, e[MW-1:0]);
        check(dec_out_burst == e[MW], {btag_q[0], " burst"}, dec_out_burst, e[MW]);
        void'(dtag_q.pop_front()); void'(btag_q.pop_front());
      end
    end
    if (enc_in_valid && enc_in_ready) enc_q.push_back(ref_encode(enc_in_msg));
    if (dec_in_valid && dec_in_ready) begin
      dec_q.push_back(pend_exp); dtag_q.push_back(pend_dtag); btag_q.push_back(pend_btag);
    end
    enc_stall = enc_out_valid && !enc_out_ready; enc_hold = enc_out_code;
    dec_stall = dec_out_valid && !dec_out_ready; dec_hold = {dec_out_burst, dec_out_msg};
    enc_in_stall = enc_in_valid && !enc_in_ready;
    dec_in_stall = dec_in_valid && !dec_in_ready;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [LW-1:0] w;
    rst_n = 1'b0;
    enc_in_valid = 0; enc_in_msg = '0; enc_out_ready = 0;
    dec_in_valid = 0; dec_in_code = '0; dec_out_ready = 0;
    repeat (3) @(negedge clk);
    check(!enc_out_valid, "R10 enc valid in reset", enc_out_valid, 0);
    check(!dec_out_valid, "R10 dec valid in reset", dec_out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 one-cycle latency, directed
    enc_out_ready = 1; dec_out_ready = 1;
    enc_in_valid = 1; enc_in_msg = 32'hA5C3_0F96;
    w = ref_encode(32'h1234_5678);
    dec_in_valid = 1; dec_in_code = w;
    pend_exp = {1'b0, 32'h1234_5678}; pend_dtag = "R3"; pend_btag = "R3";
    #1;
    check(!enc_out_valid, "R8 enc not yet valid", enc_out_valid, 0);
    check(!dec_out_valid, "R8 dec not yet valid", dec_out_valid, 0);
    tick();
    enc_in_valid = 0; dec_in_valid = 0;
    #1;
    check(enc_out_valid, "R8 enc valid after one edge", enc_out_valid, 1);
    check(dec_out_valid, "R8 dec valid after one edge", dec_out_valid, 1);
    tick();

    // parity wire alone inverted: data intact, burst raised
    w = ref_encode(32'hFFFF_0000); w[LW-1] = ~w[LW-1];
    dec_in_valid = 1; dec_in_code = w;
    pend_exp = {1'b1, 32'hFFFF_0000}; pend_dtag = "R4"; pend_btag = "R7";
    tick();
    dec_in_valid = 0;
    tick();

    // random traffic with back-pressure
    for (int c = 0; c < 6000; c++) begin
      if (!enc_in_stall) begin
        enc_in_valid = ($urandom_range(3) != 0);
        enc_in_msg   = $urandom;
      end
      if (!dec_in_stall) begin
        dec_in_valid = ($urandom_range(3) != 0);
        gen_dec(w, pend_exp, pend_dtag, pend_btag);
        dec_in_code = w;
      end
      enc_out_ready = ($urandom_range(9) < 7);
      dec_out_ready = ($urandom_range(9) < 7);
      tick();
    end

    enc_in_valid = 0; dec_in_valid = 0;
    enc_out_ready = 1; dec_out_ready = 1;
    repeat (4) tick();
    check(enc_q.size() == 0, "R8 enc words outstanding", enc_q.size(), 0);
    check(dec_q.size() == 0, "R8 dec words outstanding", dec_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule